// File: doc/BRIEF.md
# Pulse Width Demodulation Capture Unit

This block measures both phases of an external pulse train in clock cycles. A high-phase counter runs while the conditioned input is high, and a low-phase counter runs while it is low. When the input falls, the high-phase count is copied into a capture register and that counter restarts. When the input rises, the low-phase count is captured in the same way. Both edges also set their own interrupt flag. Each flag drives its interrupt output through a separate enable, and it stays set until software clears it.

The raw input first passes through a two-stage synchronizer, and the edges are detected on the synchronized level. Because both edges see the same delay, a steady pulse train is measured to the exact cycle. The whole function is gated by a mode enable. While the mode is off, both counters are held at zero, the captures keep their values, and no flag is set.

Top module: `pwd_capture`

## Requirements
- R1: After reset both capture outputs read 0 and both interrupt outputs are 0.
- R2: On a falling edge of the input, `high_width` takes the number of clock cycles for which the input was high (exact for a steady train). The high counter then restarts.
- R3: On a rising edge of the input, `low_width` takes the number of clock cycles for which the input was low. The low counter then restarts.
- R4: A rising edge sets the rise flag. `irq_rise` is 1 exactly while the rise flag is set and `ien_rise` is 1.
- R5: A falling edge sets the fall flag. `irq_fall` is 1 exactly while the fall flag is set and `ien_fall` is 1.
- R6: An edge whose interrupt enable is 0 still updates its capture register and sets its flag. Setting the enable later raises the interrupt output.
- R7: A flag stays set until its clear input is sampled high. An edge in the same cycle as a clear wins, and the flag stays set.
- R8: The counters stop at all-ones (16'hFFFF at the default width) and do not wrap.
- R9: While `mode_en` is 0, the captures do not change, no flag is set and both counters are held at 0. The first capture after enabling counts from the enabling edge, plus the 2-cycle synchronizer delay.
- R10: A capture and its flag become visible after the third rising clock edge that samples the changed input level. The first two edges fill the synchronizer and the third detects the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Enables measurement, capture and flag setting |
| pulse_in | input | 1 | Asynchronous pulse input |
| ien_rise | input | 1 | Interrupt enable for the rising-edge flag |
| ien_fall | input | 1 | Interrupt enable for the falling-edge flag |
| clr_rise | input | 1 | Clears the rising-edge flag |
| clr_fall | input | 1 | Clears the falling-edge flag |
| low_width | output | CW | Low-phase length captured on the last rising edge |
| high_width | output | CW | High-phase length captured on the last falling edge |
| irq_rise | output | 1 | Rising-edge interrupt |
| irq_fall | output | 1 | Falling-edge interrupt |

## Verification
The saturation case is the hardest to reach from the ports. It needs one input phase longer than the full counter range. The stimulus holds the input high for 70,000 cycles and then checks that the next short phase is counted from zero again.

The clear-versus-edge collision needs the clear held across the exact cycle in which the delayed edge is detected. The bench holds the clear from the input change through the detection edge, then releases it.

The first capture after enabling the mode depends on the synchronizer delay. It is checked against the enable-to-edge distance plus two.

// File: rtl/pwd_capture.sv
module pwd_capture #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_en,
  input  logic          pulse_in,
  input  logic          ien_rise,
  input  logic          ien_fall,
  input  logic          clr_rise,
  input  logic          clr_fall,
  output logic [CW-1:0] low_width,
  output logic [CW-1:0] high_width,
  output logic          irq_rise,
  output logic          irq_fall
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          sy1, sy2, sy3;
  logic [CW-1:0] hi_cnt, lo_cnt;
  logic          rise_flag, fall_flag;
  logic          rise_ev, fall_ev;

  assign rise_ev = mode_en &  sy2 & ~sy3;
  assign fall_ev = mode_en & ~sy2 &  sy3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sy1, sy2, sy3} <= 3'b000;
    else        {sy1, sy2, sy3} <= {pulse_in, sy1, sy2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (!mode_en) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (rise_ev) begin
      hi_cnt <= ONE;
      lo_cnt <= '0;
    end else if (fall_ev) begin
      hi_cnt <= '0;
      lo_cnt <= ONE;
    end else if (sy2) begin
      if (hi_cnt != CMAX) hi_cnt <= hi_cnt + ONE;
    end else begin
      if (lo_cnt != CMAX) lo_cnt <= lo_cnt + ONE;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      low_width  <= '0;
      high_width <= '0;
    end else begin
      if (rise_ev) low_width  <= lo_cnt;
      if (fall_ev) high_width <= hi_cnt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rise_flag <= 1'b0;
      fall_flag <= 1'b0;
    end else begin
      rise_flag <= rise_ev | (rise_flag & ~clr_rise);
      fall_flag <= fall_ev | (fall_flag & ~clr_fall);
    end

  assign irq_rise = rise_flag & ien_rise;
  assign irq_fall = fall_flag & ien_fall;
endmodule

module pwd_capture_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_en,
  input logic          pulse_in,
  input logic          ien_rise,
  input logic          clr_rise,
  input logic [CW-1:0] low_width,
  input logic [CW-1:0] high_width,
  input logic          irq_rise
);
  a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> ($stable(low_width) && $stable(high_width)));

  a_r2_fall_capture_origin: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(high_width) |-> ($past(pulse_in, 4) && !$past(pulse_in, 3) && $past(mode_en)));

  a_r3_rise_capture_origin: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(low_width) |-> (!$past(pulse_in, 4) && $past(pulse_in, 3) && $past(mode_en)));

  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rise && !clr_rise) |=> (irq_rise || !ien_rise));

  a_r4_rise_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rise) |-> ien_rise);
endmodule

bind pwd_capture pwd_capture_chk #(.CW(CW)) i_chk (.*);

// File: tb/test_pwd_capture.sv
module test_pwd_capture;
  localparam int CW = 16;
  localparam int NV = 6;
  localparam int VEC [NV][2] = '{'{5,4}, '{4,4}, '{10,7}, '{4,12}, '{20,5}, '{6,30}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_en = 0, pulse_in = 0, ien_rise = 0, ien_fall = 0, clr_rise = 0, clr_fall = 0;
  logic [CW-1:0] low_width, high_width;
  logic irq_rise, irq_fall;
  int checks = 0, errors = 0, prev_low;
  logic [CW-1:0] held_lo, held_hi;

  always #10 clk = ~clk;

  pwd_capture #(.CW(CW)) i_pwd_capture (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(input bit r);
    if (r) clr_rise = 1; else clr_fall = 1;
    waitn(1);
    clr_rise = 0; clr_fall = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitn(3);
    chk("R1 low_width", low_width, 0);
    chk("R1 high_width", high_width, 0);
    chk("R1 irqs", {irq_rise, irq_fall}, 0);
    rst_n = 1;
    waitn(2);
    mode_en = 1; ien_rise = 1; ien_fall = 1;
    waitn(6);
    prev_low = 8;  // R9: 6 cycles since enable plus 2 sync cycles

    for (int v = 0; v < NV; v++) begin
      pulse_in = 1;
      waitn(3);
      chk("R3 low width", low_width, prev_low);
      chk("R4/R10 irq_rise", irq_rise, 1);
      chk("R7 irq_fall cleared", irq_fall, 0);
      pulse_clr(1);
      waitn(VEC[v][0] - 4);
      pulse_in = 0;
      waitn(3);
      chk("R2 high width", high_width, VEC[v][0]);
      chk("R5/R10 irq_fall", irq_fall, 1);
      chk("R7 irq_rise cleared", irq_rise, 0);
      pulse_clr(0);
      waitn(VEC[v][1] - 4);
      prev_low = VEC[v][1];
    end

    // R6: masked rise still captures and sets flag
    ien_rise = 0;
    pulse_in = 1;
    waitn(3);
    chk("R6 masked irq_rise", irq_rise, 0);
    chk("R6 masked capture", low_width, prev_low);
    ien_rise = 1;
    #1;
    chk("R6 unmask raises irq", irq_rise, 1);
    pulse_clr(1);
    waitn(3);
    pulse_in = 0;
    waitn(3);
    chk("R2 high after mask", high_width, 7);
    pulse_clr(0);
    waitn(5);

    // R7: clear held across the detection edge
    clr_rise = 1;
    pulse_in = 1;
    waitn(3);
    clr_rise = 0;
    waitn(1);
    chk("R7 set beats clear", irq_rise, 1);
    pulse_clr(1);

    // R8: saturation
    waitn(70000 - 5);
    pulse_in = 0;
    waitn(3);
    chk("R8 saturated high", high_width, 16'hFFFF);
    pulse_clr(0);
    waitn(1);
    pulse_in = 1;
    waitn(6);
    pulse_in = 0;
    waitn(3);
    chk("R8 restart after saturation", high_width, 6);
    chk("R3 low after saturation", low_width, 5);
    pulse_clr(0);
    pulse_clr(1);
    waitn(5);

    // R9: mode off
    held_lo = low_width; held_hi = high_width;
    mode_en = 0;
    for (int k = 0; k < 4; k++) begin
      pulse_in = 1; waitn(5);
      pulse_in = 0; waitn(5);
    end
    chk("R9 low held", low_width, held_lo);
    chk("R9 high held", high_width, held_hi);
    chk("R9 no flags", {irq_rise, irq_fall}, 0);
    mode_en = 1;
    waitn(6);
    pulse_in = 1;
    waitn(3);
    chk("R9 first capture after enable", low_width, 8);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule